// File: doc/BRIEF.md
# Three-Voice Square Wave Mixer

The block turns three counter slots of a pointer-based fetch engine into tone voices. Each voice keeps an 8-bit pointer low byte, a start count, an end count and a one-bit flag. In music mode the low byte counts down on each step and reloads from the start count instead of wrapping to 0xFF. The flag goes high when the count passes the start value and low when it passes the end value, so the end count sets the duty cycle of a square wave whose period is start count plus one steps.

A step comes from a one-cycle oscillator tick input when the voice has selected the oscillator as its clock, or from a host data read of that voice's slot when the voice is out of music mode. The three gated flags form an index into a fixed nonlinear table that gives a 4-bit amplitude. The host reads that amplitude on the bus and copies it to its sound output.

Top module: `tone_mixer_top`

## Requirements
- R1: After reset every count, flag and control bit is zero, and a read of amplitude offsets 0x04–0x07 returns 0x00.
- R2: Voices are slot indices 5, 6 and 7 (slot = addr[2:0]). Writes to 0x40+slot set the start count, to 0x48+slot the end count, to 0x50+slot the pointer low byte, and to 0x58+slot the control byte. Writes whose slot is 0 to 4 change nothing observable.
- R3: In the control byte, bit 4 enables music mode, bit 5 selects the oscillator tick (1) or the slot's data read (0) as the clock, and bits 3:0 are the pointer high bits. Bits 7:6 are ignored.
- R4: On a music-mode step the low byte reloads from the start count when it is 0x00, and otherwise decrements by one.
- R5: On every step the flag is set if the low byte (before the step) equals the start count. Otherwise it is cleared if the low byte equals the end count. Otherwise it holds.
- R6: A tick steps exactly the voices with music mode 1 and clock select 1. A music voice with clock select 0 does not move on ticks.
- R7: A read with addr[6]=0, addr[5:3] in 1 to 6 and slot 5 to 7 is a data read. It steps that voice with a plain 12-bit pointer decrement when the voice is out of music mode, and has no effect on a voice in music mode.
- R8: A pointer-low write to a voice in music mode loads the start count and discards the written value. Out of music mode, the written value is loaded.
- R9: The mixing index is {voice5, voice6, voice7}, with voice 5 as the most significant bit. Each bit is the voice's flag AND its music enable. Indices 0 to 7 give amplitudes 0x0, 0x4, 0x5, 0x9, 0x6, 0xA, 0xB, 0xF.
- R10: A read at 0x04–0x07 returns the amplitude in bits 3:0 with bits 7:4 zero. Every other read address, and every cycle without a read, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle oscillator tick enable |
| addr_i | input | 7 | Bus offset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Bus write data |
| rd_en_i | input | 1 | Bus read strobe |
| rd_data_o | output | 8 | Read data (amplitude or zero) |

## Verification
Each voice is swept alone through all 64 start and end pairs in the range 0 to 7, which separates the reload point, the period and the set-before-clear priority when start equals end. A long run with all three voices at different periods passes through every mixing index, so any wrong table entry or swapped voice order shows up. Directed phases separate the two clock sources. They show that ticks freeze a voice whose clock select is zero, that data reads move only non-music voices (seen as a phase shift once music mode is turned on), and that a pointer-low write in music mode loads the start count. Writes to slots 0 to 4 and reads of non-amplitude addresses are checked to leave the outputs at their expected values.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned HI_W       = 4;
  localparam int unsigned AMP_W      = 4;
  localparam int unsigned SLOT_W     = 3;
  // register group codes in addr[5:3] when addr[6] = 1
  localparam logic [2:0] GRP_START  = 3'd0;
  localparam logic [2:0] GRP_END    = 3'd1;
  localparam logic [2:0] GRP_PTR_LO = 3'd2;
  localparam logic [2:0] GRP_CTRL   = 3'd3;
  // control byte fields
  localparam int unsigned CTRL_MUSIC_BIT = 4;
  localparam int unsigned CTRL_OSC_BIT   = 5;

  typedef struct packed {
    logic wr_start;
    logic wr_end;
    logic wr_lo;
    logic wr_ctrl;
    logic data_rd;
  } voice_strb_t;

  function automatic logic [AMP_W-1:0] amp_lut(input logic [2:0] idx);
    logic [AMP_W-1:0] a;
    unique case (idx)
      3'd0: a = 4'h0;
      3'd1: a = 4'h4;
      3'd2: a = 4'h5;
      3'd3: a = 4'h9;
      3'd4: a = 4'h6;
      3'd5: a = 4'hA;
      3'd6: a = 4'hB;
      default: a = 4'hF;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/tone_bus_dec.sv
module tone_bus_dec
  import tone_pkg::*;
#(
  parameter int unsigned NUM_VOICES  = 3,
  parameter int unsigned FIRST_VOICE = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output voice_strb_t       strb_o [NUM_VOICES],
  output logic              amp_sel_o
);
  logic [2:0] grp;
  logic       reg_space;
  logic       data_space;
  assign grp        = addr_i[5:3];
  assign reg_space  = addr_i[6];
  assign data_space = ~addr_i[6] && (grp != 3'd0) && (grp != 3'd7);
  assign amp_sel_o  = rd_en_i && (addr_i[6:2] == 5'b00001);

  for (genvar g = 0; g < NUM_VOICES; g++) begin : g_dec
    localparam logic [SLOT_W-1:0] SLOT = SLOT_W'(FIRST_VOICE + g);
    logic hit;
    assign hit = (addr_i[SLOT_W-1:0] == SLOT);
    always_comb begin
      strb_o[g].wr_start = wr_en_i && reg_space && hit && (grp == GRP_START);
      strb_o[g].wr_end   = wr_en_i && reg_space && hit && (grp == GRP_END);
      strb_o[g].wr_lo    = wr_en_i && reg_space && hit && (grp == GRP_PTR_LO);
      strb_o[g].wr_ctrl  = wr_en_i && reg_space && hit && (grp == GRP_CTRL);
      strb_o[g].data_rd  = rd_en_i && data_space && hit;
    end
  end
endmodule

// File: rtl/tone_voice.sv
module tone_voice
  import tone_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  voice_strb_t       strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic              flag_o,
  output logic              music_o,
  output logic              osc_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] start_o
);
  logic [DATA_W-1:0] lo_q, start_q, end_q;
  logic [HI_W-1:0]   hi_q;
  logic              music_q, osc_q, flag_q;
  logic              step;
  logic [HI_W+DATA_W-1:0] ptr_dec;

  assign step    = (tick_i && music_q && osc_q) || (strb_i.data_rd && !music_q);
  assign ptr_dec = {hi_q, lo_q} - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else begin
      if (strb_i.wr_start) start_q <= wdata_i;
      if (strb_i.wr_end)   end_q   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      music_q <= 1'b0;
      osc_q   <= 1'b0;
    end else if (strb_i.wr_ctrl) begin
      music_q <= wdata_i[CTRL_MUSIC_BIT];
      osc_q   <= wdata_i[CTRL_OSC_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (strb_i.wr_lo)           lo_q <= music_q ? start_q : wdata_i;
      else if (step && music_q)   lo_q <= (lo_q == '0) ? start_q : lo_q - 1'b1;
      else if (step)              lo_q <= ptr_dec[DATA_W-1:0];

      if (strb_i.wr_ctrl)         hi_q <= wdata_i[HI_W-1:0];
      else if (step && !music_q)  hi_q <= ptr_dec[HI_W+DATA_W-1:DATA_W];
    end
  end

  // start match wins over end match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= 1'b0;
    else if (step && lo_q == start_q)   flag_q <= 1'b1;
    else if (step && lo_q == end_q)     flag_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  assign music_o = music_q;
  assign osc_o   = osc_q;
  assign lo_o    = lo_q;
  assign start_o = start_q;
endmodule

// File: rtl/tone_mix.sv
module tone_mix
  import tone_pkg::*;
#(
  parameter int unsigned NUM_VOICES = 3
) (
  input  logic [NUM_VOICES-1:0] flag_i,
  input  logic [NUM_VOICES-1:0] music_i,
  output logic [AMP_W-1:0]      amp_o
);
  logic [2:0] idx;
  // voice 0 (slot 5) is the index MSB
  for (genvar g = 0; g < 3; g++) begin : g_idx
    if (g < NUM_VOICES) begin : g_on
      assign idx[2-g] = flag_i[g] & music_i[g];
    end else begin : g_off
      assign idx[2-g] = 1'b0;
    end
  end
  assign amp_o = amp_lut(idx);
endmodule

// File: rtl/tone_mixer_top.sv
module tone_mixer_top
  import tone_pkg::*;
#(
  parameter int unsigned NUM_VOICES  = 3,
  parameter int unsigned FIRST_VOICE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  output logic [7:0]        rd_data_o
);
  voice_strb_t                     strb [NUM_VOICES];
  logic                            amp_sel;
  logic [NUM_VOICES-1:0]           flag_w, music_w, osc_w;
  logic [NUM_VOICES-1:0][DATA_W-1:0] lo_w, start_w;
  logic [AMP_W-1:0]                amp;

  tone_bus_dec #(.NUM_VOICES(NUM_VOICES), .FIRST_VOICE(FIRST_VOICE)) u_dec (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .strb_o(strb), .amp_sel_o(amp_sel)
  );

  for (genvar g = 0; g < NUM_VOICES; g++) begin : g_voice
    tone_voice u_voice (
      .clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb[g]), .wdata_i(wr_data_i),
      .tick_i(tick_i), .flag_o(flag_w[g]), .music_o(music_w[g]), .osc_o(osc_w[g]),
      .lo_o(lo_w[g]), .start_o(start_w[g])
    );
  end

  tone_mix #(.NUM_VOICES(NUM_VOICES)) u_mix (
    .flag_i(flag_w), .music_i(music_w), .amp_o(amp)
  );

  assign rd_data_o = amp_sel ? {{(DATA_W-AMP_W){1'b0}}, amp} : '0;
endmodule

// File: rtl/tone_chk.sv
module tone_chk #(
  parameter int unsigned NV = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [6:0]        addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        rd_data_o,
  input logic [NV-1:0]     flag_i,
  input logic [NV-1:0]     music_i,
  input logic [NV-1:0]     osc_i,
  input logic [NV-1:0][7:0] lo_i,
  input logic [NV-1:0][7:0] start_i
);
  logic amp_rd;
  assign amp_rd = rd_en_i && (addr_i[6:2] == 5'b00001);

  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_rd |-> rd_data_o[7:4] == 4'h0);
  a_r10_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_rd |-> rd_data_o == 8'h00);
  a_r9_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_rd && music_i == '0) |-> rd_data_o == 8'h00);

  for (genvar g = 0; g < NV; g++) begin : g_v
    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && music_i[g] && osc_i[g] && lo_i[g] == 8'h00 && !wr_en_i)
      |=> lo_i[g] == $past(start_i[g]));
    a_r6_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (music_i[g] && !(tick_i && osc_i[g]) && !wr_en_i) |=> $stable(lo_i[g]));
    a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && music_i[g] && osc_i[g] && lo_i[g] == start_i[g] && !wr_en_i)
      |=> flag_i[g]);
  end
endmodule

bind tone_mixer_top tone_chk #(.NV(NUM_VOICES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .flag_i(flag_w), .music_i(music_w), .osc_i(osc_w), .lo_i(lo_w), .start_i(start_w)
);

// File: tb/tb_tone_mixer_top.sv
module tb_tone_mixer_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the three voices (index 0..2 = slot 5..7)
  logic [7:0] m_lo [3];
  logic [7:0] m_st [3];
  logic [7:0] m_en [3];
  logic       m_fl [3];
  logic       m_mu [3];
  logic       m_ck [3];

  always #5 clk_i = ~clk_i;

  tone_mixer_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o)
  );

  task automatic m_step(input int v, input bit mus);
    if (m_lo[v] == m_st[v])      m_fl[v] = 1'b1;
    else if (m_lo[v] == m_en[v]) m_fl[v] = 1'b0;
    if (mus && m_lo[v] == 8'h00) m_lo[v] = m_st[v];
    else                         m_lo[v] = m_lo[v] - 8'd1;
  endtask

  function automatic logic [7:0] m_amp();
    int a = 0;
    if (m_fl[0] && m_mu[0]) a += 6;
    if (m_fl[1] && m_mu[1]) a += 5;
    if (m_fl[2] && m_mu[2]) a += 4;
    return 8'(a);
  endfunction

  task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
    int v;
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a[6] && a[2:0] >= 3'd5) begin
      v = int'(a[2:0]) - 5;
      case (a[5:3])
        3'd0: m_st[v] = d;
        3'd1: m_en[v] = d;
        3'd2: m_lo[v] = m_mu[v] ? m_st[v] : d;
        3'd3: begin m_mu[v] = d[4]; m_ck[v] = d[5]; end
        default: ;
      endcase
    end
  endtask

  task automatic do_tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    for (int v = 0; v < 3; v++) if (m_mu[v] && m_ck[v]) m_step(v, 1'b1);
  endtask

  task automatic do_drd(input logic [6:0] a);
    int v;
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    if (!a[6] && a[5:3] != 3'd0 && a[5:3] != 3'd7 && a[2:0] >= 3'd5) begin
      v = int'(a[2:0]) - 5;
      if (!m_mu[v]) m_step(v, 1'b0);
    end
  endtask

  task automatic chk_rd(input logic [6:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1;
    n_chk++;
    if (rd_data_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data_o, exp);
    end
    #1 rd_en_i = 1'b0;
  endtask

  task automatic chk_amp(input string req);
    chk_rd(7'h04 + 7'(n_chk % 4), m_amp(), req);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int v = 0; v < 3; v++) begin
      m_lo[v] = 0; m_st[v] = 0; m_en[v] = 0; m_fl[v] = 0; m_mu[v] = 0; m_ck[v] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state on all amplitude offsets
    for (int k = 0; k < 4; k++) chk_rd(7'h04 + 7'(k), 8'h00, "R1");

    // R2 slots 0..4 are not voices: writes must not reach the outputs
    for (int s = 0; s < 5; s++) begin
      do_wr(7'h40 + 7'(s), 8'h03);
      do_wr(7'h58 + 7'(s), 8'h30);
      do_wr(7'h50 + 7'(s), 8'h00);
    end
    for (int t = 0; t < 6; t++) begin do_tick(); chk_amp("R2"); end

    // R4 R5 R6 R8 R9: each voice alone, all start/end pairs 0..7
    for (int v = 0; v < 3; v++) begin
      for (int s = 0; s < 8; s++) begin
        for (int e = 0; e < 8; e++) begin
          do_wr(7'h40 + 7'(5 + v), 8'(s));
          do_wr(7'h48 + 7'(5 + v), 8'(e));
          do_wr(7'h58 + 7'(5 + v), 8'hF0 | 8'h30);   // R3 bits 7:6 ignored
          do_wr(7'h50 + 7'(5 + v), 8'hA5);           // R8 loads start
          for (int t = 0; t < 2 * s + 4; t++) begin do_tick(); chk_amp("R4/R5"); end
        end
      end
      do_wr(7'h58 + 7'(5 + v), 8'h00);
      chk_amp("R9 voice off");
    end

    // R9 all voices running at different periods: every index visited
    do_wr(7'h45, 8'd3); do_wr(7'h4D, 8'd1);
    do_wr(7'h46, 8'd4); do_wr(7'h4E, 8'd2);
    do_wr(7'h47, 8'd6); do_wr(7'h4F, 8'd3);
    for (int v = 0; v < 3; v++) do_wr(7'h5D + 7'(v), 8'h3A);
    for (int v = 0; v < 3; v++) do_wr(7'h55 + 7'(v), 8'h00);
    for (int t = 0; t < 300; t++) begin do_tick(); chk_amp("R9"); end

    // R6 clock select 0 freezes a music voice on ticks
    do_wr(7'h5D, 8'h10);
    for (int t = 0; t < 20; t++) begin do_tick(); chk_amp("R6"); end
    do_wr(7'h5D, 8'h30);
    for (int t = 0; t < 10; t++) begin do_tick(); chk_amp("R6"); end

    // R7 data reads on music voices change nothing
    for (int g = 1; g < 7; g++) for (int v = 5; v < 8; v++) do_drd(7'(g * 8 + v));
    for (int t = 0; t < 12; t++) begin do_tick(); chk_amp("R7 music"); end

    // R7 data reads step a non-music voice (phase visible after enabling)
    for (int v = 0; v < 3; v++) do_wr(7'h5D + 7'(v), 8'h00);
    do_wr(7'h46, 8'd9); do_wr(7'h4E, 8'd4); do_wr(7'h56, 8'd6);
    for (int r = 0; r < 4; r++) do_drd(7'h0E + 7'(8 * r));
    do_drd(7'h0B);                                   // slot 3: no voice
    do_wr(7'h5E, 8'h30);
    for (int t = 0; t < 25; t++) begin do_tick(); chk_amp("R7 non-music"); end
    // R8 a pointer-low write in music mode takes the start count
    do_wr(7'h56, 8'h02);
    for (int t = 0; t < 12; t++) begin do_tick(); chk_amp("R8"); end
    // R8 out of music mode the written value is loaded
    do_wr(7'h5E, 8'h00); do_wr(7'h56, 8'h02); do_wr(7'h5E, 8'h30);
    for (int t = 0; t < 12; t++) begin do_tick(); chk_amp("R8"); end

    // R10 non-amplitude addresses read zero
    chk_rd(7'h00, 8'h00, "R10");
    chk_rd(7'h0E, 8'h00, "R10");
    chk_rd(7'h3E, 8'h00, "R10");
    chk_rd(7'h5E, 8'h00, "R10");
    for (int k = 0; k < 4; k++) chk_rd(7'h04 + 7'(k), m_amp(), "R10");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule